// File: doc/BRIEF.md
# Address Window Validity Decoder

This block turns the base-address registers of one configurable function into decoded address windows, then matches incoming accesses against those windows. There are up to seven regions: six general regions plus a final expansion-ROM region. For each region it computes an effective base by aligning the stored register value to the region size. The window is accepted only if the matching space-enable control is on and the window is not degenerate. Otherwise the region is reported as unmapped, and its effective base reads as all-ones.

The configuration register file pulses an update strobe after any write that may move a window. One cycle later the decoder latches the new windows. Each region whose effective base changed then raises an unmap pulse, if its old window was live, and one cycle after that a map pulse, if its new window is live. An access is offered as an address, a space flag and a valid strobe. The decoder never applies back-pressure, because an access can always be decoded. It returns a one-hot hit vector in the same cycle.

Top module: `bar_window_decoder`

## Requirements
- R1: An I/O region decodes only while `io_space_en` is 1. A memory region, including the ROM region, decodes only while `mem_space_en` is 1.
- R2: The effective base is the register value ANDed with the inverse of (size-1). The window covers base through base+size-1, inclusive. An unmapped region has `eff_valid` 0 and an effective base of all-ones.
- R3: An I/O window is rejected if its base is zero, if its last address is not above its base, or if its last address is 0x10000 or higher.
- R4: A memory window is rejected if its base is zero, if its last address is not above its base, or if its last address is all-ones.
- R5: The highest-index region is the ROM region. It is always memory, and it is accepted only when bit 0 of its register value is 1.
- R6: A region whose size is zero is never decoded.
- R7: Window state changes only on the clock edge that samples `upd_strobe` high. Register, size and enable changes made without the strobe have no effect.
- R8: `hit_vec` is zero unless `acc_valid` is 1. It holds at most one bit, set for the lowest-index live region whose space matches `acc_is_io` and whose window contains `acc_addr`.
- R9: A region's events fire only when its effective base changes. `unmap_pulse` rises in the latch cycle if the old window was live. `map_pulse` rises one cycle later if the new window is live.
- R10: After reset, every region is unmapped, with all-ones bases, and no hit or pulse is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_space_en | input | 1 | Command I/O-space enable |
| mem_space_en | input | 1 | Command memory-space enable |
| bar_flat | input | NUM_REGIONS*ADDR_W | Stored register value per region, region i at slice i |
| size_flat | input | NUM_REGIONS*ADDR_W | Power-of-two region size, 0 = absent |
| region_is_io | input | NUM_REGIONS | 1 = I/O region (ignored for ROM) |
| upd_strobe | input | 1 | Configuration changed; latch windows |
| acc_valid | input | 1 | Access present |
| acc_addr | input | ADDR_W | Access address |
| acc_is_io | input | 1 | 1 = I/O space access, 0 = memory |
| hit_vec | output | NUM_REGIONS | One-hot region hit |
| eff_valid | output | NUM_REGIONS | Region window is live |
| eff_base_flat | output | NUM_REGIONS*ADDR_W | Effective base per region |
| map_pulse | output | NUM_REGIONS | New window became live |
| unmap_pulse | output | NUM_REGIONS | Old window withdrawn |

## Verification
The bench probes each rejection edge on both sides. An I/O window ending exactly at 0xFFFF must be accepted, while one crossing 0x10000 must be refused. A memory window ending at all-ones, a zero base, and a one-byte window whose last address equals its base must all be refused. A decoder that used the wrong comparison would map these windows and claim accesses that belong elsewhere. The ROM test toggles only the enable bit, and the overlap test places two identical windows so that a broken priority encoder shows two hits or the wrong one. The event tests move a live window, then re-strobe without a change, to catch pulses that fire in the wrong order or fire on every strobe.

// File: rtl/bwd_pkg.sv
package bwd_pkg;
  // Value reported as the base of a region with no live window.
  localparam logic UNMAPPED_FILL = 1'b1;

  typedef enum logic {
    SPACE_MEM = 1'b0,
    SPACE_IO  = 1'b1
  } space_e;
endpackage

// File: rtl/bar_window_calc.sv
module bar_window_calc
  import bwd_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int IO_SPAN_W = 16,
  parameter bit IS_ROM    = 1'b0
) (
  input  logic [ADDR_W-1:0] bar_val,
  input  logic [ADDR_W-1:0] size_val,
  input  logic              is_io,
  input  logic              io_en,
  input  logic              mem_en,
  output logic [ADDR_W-1:0] win_base,
  output logic [ADDR_W-1:0] win_last,
  output logic              win_ok,
  output space_e            win_space
);
  localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  logic [ADDR_W-1:0] align_mask;
  logic              shape_ok;
  logic              io_ok;
  logic              mem_ok;
  logic              rom_gate;

  // The ROM region is always a memory window with its own enable bit.
  generate
    if (IS_ROM) begin : g_rom
      assign win_space = SPACE_MEM;
      assign rom_gate  = bar_val[0];
    end else begin : g_plain
      assign win_space = is_io ? SPACE_IO : SPACE_MEM;
      assign rom_gate  = 1'b1;
    end
  endgenerate

  always_comb begin
    align_mask = ~(size_val - ONE);
    win_base   = bar_val & align_mask;
    win_last   = win_base + size_val - ONE;
    shape_ok   = (size_val != '0) && (win_last > win_base) && (win_base != '0);
    io_ok      = io_en && shape_ok && ((win_last >> IO_SPAN_W) == '0);
    mem_ok     = mem_en && shape_ok && (win_last != '1) && rom_gate;
    win_ok     = (win_space == SPACE_IO) ? io_ok : mem_ok;
  end
endmodule

// File: rtl/bwd_region_state.sv
module bwd_region_state
  import bwd_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_strobe,
  input  logic [ADDR_W-1:0] nxt_base,
  input  logic [ADDR_W-1:0] nxt_last,
  input  logic              nxt_ok,
  input  space_e            nxt_space,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_is_io,
  output logic [ADDR_W-1:0] eff_base,
  output logic              eff_ok,
  output logic              raw_match,
  output logic              map_ev,
  output logic              unmap_ev
);
  logic [ADDR_W-1:0] base_q, last_q, nxt_eff;
  logic              ok_q, map_pend_q, map_q, unmap_q, moved;
  space_e            space_q;

  always_comb begin
    nxt_eff = nxt_ok ? nxt_base : {ADDR_W{UNMAPPED_FILL}};
    moved   = (nxt_eff != base_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q     <= {ADDR_W{UNMAPPED_FILL}};
      last_q     <= '0;
      ok_q       <= 1'b0;
      space_q    <= SPACE_MEM;
      unmap_q    <= 1'b0;
      map_pend_q <= 1'b0;
      map_q      <= 1'b0;
    end else begin
      map_q <= map_pend_q;
      if (upd_strobe) begin
        base_q     <= nxt_eff;
        last_q     <= nxt_last;
        ok_q       <= nxt_ok;
        space_q    <= nxt_space;
        unmap_q    <= moved && ok_q;
        map_pend_q <= moved && nxt_ok;
      end else begin
        unmap_q    <= 1'b0;
        map_pend_q <= 1'b0;
      end
    end
  end

  assign eff_base  = base_q;
  assign eff_ok    = ok_q;
  assign map_ev    = map_q;
  assign unmap_ev  = unmap_q;
  assign raw_match = acc_valid && ok_q && (space_q == (acc_is_io ? SPACE_IO : SPACE_MEM))
                     && (acc_addr >= base_q) && (acc_addr <= last_q);
endmodule

// File: rtl/bwd_hit_arbiter.sv
module bwd_hit_arbiter #(
  parameter int NUM_REGIONS = 7
) (
  input  logic [NUM_REGIONS-1:0] raw_match,
  output logic [NUM_REGIONS-1:0] hit_onehot
);
  logic [NUM_REGIONS-1:0] taken;

  // Lower index wins: a region is blocked once any lower region matched.
  generate
    for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_chain
      if (i == 0) begin : g_first
        assign taken[i] = raw_match[i];
        assign hit_onehot[i] = raw_match[i];
      end else begin : g_rest
        assign taken[i] = taken[i-1] | raw_match[i];
        assign hit_onehot[i] = raw_match[i] & ~taken[i-1];
      end
    end
  endgenerate
endmodule

// File: rtl/bar_window_decoder.sv
module bar_window_decoder
  import bwd_pkg::*;
#(
  parameter int NUM_REGIONS = 7,
  parameter int ADDR_W      = 32,
  parameter int IO_SPAN_W   = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          io_space_en,
  input  logic                          mem_space_en,
  input  logic [NUM_REGIONS*ADDR_W-1:0] bar_flat,
  input  logic [NUM_REGIONS*ADDR_W-1:0] size_flat,
  input  logic [NUM_REGIONS-1:0]        region_is_io,
  input  logic                          upd_strobe,
  input  logic                          acc_valid,
  input  logic [ADDR_W-1:0]             acc_addr,
  input  logic                          acc_is_io,
  output logic [NUM_REGIONS-1:0]        hit_vec,
  output logic [NUM_REGIONS-1:0]        eff_valid,
  output logic [NUM_REGIONS*ADDR_W-1:0] eff_base_flat,
  output logic [NUM_REGIONS-1:0]        map_pulse,
  output logic [NUM_REGIONS-1:0]        unmap_pulse
);
  localparam int ROM_IDX = NUM_REGIONS - 1;

  logic [NUM_REGIONS-1:0] raw_match;

  generate
    for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
      logic [ADDR_W-1:0] c_base, c_last;
      logic              c_ok;
      space_e            c_space;

      bar_window_calc #(
        .ADDR_W(ADDR_W), .IO_SPAN_W(IO_SPAN_W), .IS_ROM(r == ROM_IDX)
      ) calc_i (
        .bar_val  (bar_flat[r*ADDR_W +: ADDR_W]),
        .size_val (size_flat[r*ADDR_W +: ADDR_W]),
        .is_io    (region_is_io[r]),
        .io_en    (io_space_en),
        .mem_en   (mem_space_en),
        .win_base (c_base),
        .win_last (c_last),
        .win_ok   (c_ok),
        .win_space(c_space)
      );

      bwd_region_state #(.ADDR_W(ADDR_W)) state_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_strobe(upd_strobe),
        .nxt_base  (c_base),
        .nxt_last  (c_last),
        .nxt_ok    (c_ok),
        .nxt_space (c_space),
        .acc_valid (acc_valid),
        .acc_addr  (acc_addr),
        .acc_is_io (acc_is_io),
        .eff_base  (eff_base_flat[r*ADDR_W +: ADDR_W]),
        .eff_ok    (eff_valid[r]),
        .raw_match (raw_match[r]),
        .map_ev    (map_pulse[r]),
        .unmap_ev  (unmap_pulse[r])
      );
    end
  endgenerate

  bwd_hit_arbiter #(.NUM_REGIONS(NUM_REGIONS)) arb_i (
    .raw_match (raw_match),
    .hit_onehot(hit_vec)
  );
endmodule

// File: rtl/bwd_checker.sv
module bwd_checker #(
  parameter int NUM_REGIONS = 7,
  parameter int ADDR_W      = 32
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          upd_strobe,
  input logic                          acc_valid,
  input logic [NUM_REGIONS-1:0]        hit_vec,
  input logic [NUM_REGIONS-1:0]        eff_valid,
  input logic [NUM_REGIONS*ADDR_W-1:0] eff_base_flat,
  input logic [NUM_REGIONS-1:0]        unmap_pulse
);
  AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)); // R8
  AST_HIT_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vec != '0) |-> acc_valid); // R8
  AST_HIT_ON_LIVE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vec & ~eff_valid) == '0); // R8
  AST_HOLD_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_strobe |=> $stable(eff_base_flat)); // R7
  AST_UNMAP_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_strobe |=> (unmap_pulse == '0)); // R9
endmodule

bind bar_window_decoder bwd_checker #(
  .NUM_REGIONS(NUM_REGIONS), .ADDR_W(ADDR_W)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .upd_strobe   (upd_strobe),
  .acc_valid    (acc_valid),
  .hit_vec      (hit_vec),
  .eff_valid    (eff_valid),
  .eff_base_flat(eff_base_flat),
  .unmap_pulse  (unmap_pulse)
);

// File: tb/bar_window_decoder_tb_top.sv
`timescale 1ns/1ps
module bar_window_decoder_tb_top;
  localparam int N = 7;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic io_en = 1'b0, mem_en = 1'b0;
  logic [AW-1:0] bar_r [N];
  logic [AW-1:0] size_r [N];
  logic [N-1:0] is_io_r = '0;
  logic [N*AW-1:0] bar_flat, size_flat;
  logic upd = 1'b0, acc_valid = 1'b0, acc_io = 1'b0;
  logic [AW-1:0] acc_addr = '0;
  logic [N-1:0] hit_vec, eff_valid, map_pulse, unmap_pulse;
  logic [N*AW-1:0] eff_base_flat;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  always_comb
    for (int i = 0; i < N; i++) begin
      bar_flat[i*AW +: AW]  = bar_r[i];
      size_flat[i*AW +: AW] = size_r[i];
    end

  bar_window_decoder #(.NUM_REGIONS(N), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .io_space_en(io_en), .mem_space_en(mem_en),
    .bar_flat(bar_flat), .size_flat(size_flat), .region_is_io(is_io_r),
    .upd_strobe(upd), .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_is_io(acc_io),
    .hit_vec(hit_vec), .eff_valid(eff_valid), .eff_base_flat(eff_base_flat),
    .map_pulse(map_pulse), .unmap_pulse(unmap_pulse));

  typedef struct packed {
    logic [31:0] bar;
    logic [31:0] size;
    logic        is_io;
    logic        io_en;
    logic        mem_en;
    logic [31:0] addr;
    logic        acc_io;
    logic        exp_ok;
    logic [31:0] exp_base;
    logic        exp_hit;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{32'h8000_1234, 32'h1000, 1'b0, 1'b0, 1'b1, 32'h8000_1FFF, 1'b0, 1'b1, 32'h8000_1000, 1'b1},
    '{32'h8000_1234, 32'h1000, 1'b0, 1'b0, 1'b1, 32'h8000_2000, 1'b0, 1'b1, 32'h8000_1000, 1'b0},
    '{32'h8000_1234, 32'h1000, 1'b0, 1'b1, 1'b0, 32'h8000_1000, 1'b0, 1'b0, 32'hFFFF_FFFF, 1'b0},
    '{32'h0000_0FFF, 32'h1000, 1'b0, 1'b0, 1'b1, 32'h0000_0000, 1'b0, 1'b0, 32'hFFFF_FFFF, 1'b0},
    '{32'hFFFF_F000, 32'h1000, 1'b0, 1'b0, 1'b1, 32'hFFFF_F000, 1'b0, 1'b0, 32'hFFFF_FFFF, 1'b0},
    '{32'h0000_C001, 32'h0020, 1'b1, 1'b1, 1'b0, 32'h0000_C01F, 1'b1, 1'b1, 32'h0000_C000, 1'b1},
    '{32'h0000_FFF3, 32'h0010, 1'b1, 1'b1, 1'b0, 32'h0000_FFF0, 1'b1, 1'b1, 32'h0000_FFF0, 1'b1},
    '{32'h0001_0004, 32'h0010, 1'b1, 1'b1, 1'b0, 32'h0001_0000, 1'b1, 1'b0, 32'hFFFF_FFFF, 1'b0},
    '{32'h0000_C000, 32'h0020, 1'b1, 1'b1, 1'b0, 32'h0000_C000, 1'b0, 1'b1, 32'h0000_C000, 1'b0},
    '{32'h8000_0000, 32'h0000, 1'b0, 1'b0, 1'b1, 32'h8000_0000, 1'b0, 1'b0, 32'hFFFF_FFFF, 1'b0},
    '{32'h0000_0100, 32'h0001, 1'b0, 1'b0, 1'b1, 32'h0000_0100, 1'b0, 1'b0, 32'hFFFF_FFFF, 1'b0},
    '{32'h0000_C000, 32'h0020, 1'b1, 1'b0, 1'b1, 32'h0000_C000, 1'b1, 1'b0, 32'hFFFF_FFFF, 1'b0}
  };

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_regions();
    for (int i = 0; i < N; i++) begin
      bar_r[i] = '0;
      size_r[i] = '0;
    end
    is_io_r = '0;
  endtask

  // Pulse the strobe for one edge; returns at the negedge after the latch edge.
  task automatic strobe();
    @(negedge clk) upd = 1'b1;
    @(negedge clk) upd = 1'b0;
  endtask

  function automatic logic [AW-1:0] base_of(input int r);
    return eff_base_flat[r*AW +: AW];
  endfunction

  initial begin
    #400000;
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    clear_regions();
    acc_valid = 1'b1;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(eff_valid == '0, "R10 valid after reset", 64'(eff_valid), 64'h0);
    chk(eff_base_flat == '1, "R10 base after reset", 64'(base_of(0)), 64'hFFFF_FFFF);
    chk(hit_vec == '0 && map_pulse == '0 && unmap_pulse == '0, "R10 idle outputs",
        64'(hit_vec), 64'h0);
    rst_n = 1'b1;

    // Vector table on region 0 (R1 R2 R3 R4 R6 R8)
    foreach (VECS[k]) begin
      @(negedge clk);
      clear_regions();
      bar_r[0] = VECS[k].bar;
      size_r[0] = VECS[k].size;
      is_io_r[0] = VECS[k].is_io;
      io_en = VECS[k].io_en;
      mem_en = VECS[k].mem_en;
      acc_addr = VECS[k].addr;
      acc_io = VECS[k].acc_io;
      strobe();
      chk(eff_valid[0] == VECS[k].exp_ok, $sformatf("R1 R3 R4 R6 vector %0d valid", k),
          64'(eff_valid[0]), 64'(VECS[k].exp_ok));
      chk(base_of(0) == VECS[k].exp_base, $sformatf("R2 vector %0d base", k),
          64'(base_of(0)), 64'(VECS[k].exp_base));
      chk(hit_vec == (VECS[k].exp_hit ? 7'b1 : 7'b0), $sformatf("R8 vector %0d hit", k),
          64'(hit_vec), 64'(VECS[k].exp_hit));
    end

    // R5: ROM region needs bit 0
    clear_regions();
    io_en = 1'b0; mem_en = 1'b1; acc_io = 1'b0;
    bar_r[N-1] = 32'h000C_0000; size_r[N-1] = 32'h0001_0000; is_io_r[N-1] = 1'b1;
    acc_addr = 32'h000C_8000;
    strobe();
    chk(eff_valid[N-1] == 1'b0 && hit_vec == '0, "R5 rom disabled", 64'(eff_valid), 64'h0);
    bar_r[N-1] = 32'h000C_0001;
    strobe();
    chk(eff_valid[N-1] && base_of(N-1) == 32'h000C_0000, "R5 rom enabled base",
        64'(base_of(N-1)), 64'h000C_0000);
    chk(hit_vec == 7'b100_0000, "R5 rom hit as memory", 64'(hit_vec), 64'h40);

    // R8: overlap priority and access gating
    clear_regions();
    bar_r[1] = 32'h2000_0000; size_r[1] = 32'h100;
    bar_r[3] = 32'h2000_0000; size_r[3] = 32'h100;
    acc_addr = 32'h2000_0010;
    strobe();
    chk(hit_vec == 7'b000_0010, "R8 lowest index wins", 64'(hit_vec), 64'h2);
    acc_valid = 1'b0;
    #1;
    chk(hit_vec == '0, "R8 no hit without acc_valid", 64'(hit_vec), 64'h0);
    acc_valid = 1'b1;

    // R7: changes without strobe ignored
    bar_r[1] = 32'h3000_0000; mem_en = 1'b0;
    repeat (3) @(negedge clk);
    chk(base_of(1) == 32'h2000_0000 && eff_valid[1], "R7 hold without strobe",
        64'(base_of(1)), 64'h2000_0000);
    mem_en = 1'b1;

    // R9: event ordering
    clear_regions();
    strobe();
    @(negedge clk);
    bar_r[0] = 32'h4000_0000; size_r[0] = 32'h1000;
    strobe();
    chk(unmap_pulse == '0 && map_pulse == '0, "R9 first map latch cycle",
        64'({unmap_pulse, map_pulse}), 64'h0);
    @(negedge clk);
    chk(map_pulse == 7'b1 && unmap_pulse == '0, "R9 map one cycle later",
        64'(map_pulse), 64'h1);
    bar_r[0] = 32'h4000_2000;
    strobe();
    chk(unmap_pulse == 7'b1 && map_pulse == '0, "R9 unmap on move",
        64'({unmap_pulse, map_pulse}), 64'h80);
    @(negedge clk);
    chk(map_pulse == 7'b1 && unmap_pulse == '0, "R9 map after unmap",
        64'(map_pulse), 64'h1);
    strobe();
    chk(unmap_pulse == '0 && map_pulse == '0, "R9 no event unchanged (latch)",
        64'({unmap_pulse, map_pulse}), 64'h0);
    @(negedge clk);
    chk(map_pulse == '0, "R9 no event unchanged (next)", 64'(map_pulse), 64'h0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule